// File: doc/BRIEF.md
# Inclusive Hybrid Last-Level Cache Victim Handler

This block decides what happens to a line leaving either half of a last-level cache that is built from a fast SRAM part and a large DRAM part, while the cache stays inclusive of the private L1/L2 caches. An eviction arrives as a valid/ready transfer that carries the victim's source half, its line address and its dirty bit. The block then asks the other half whether it still holds the line. For an SRAM victim it asks the presence filter of the DRAM part. For a DRAM victim it asks the SRAM tags. The one-bit hit answer, together with the source and the dirty bit, selects up to two commands: a back-invalidation of the private caches, a writeback into the DRAM part, or a writeback to main memory through the writeback buffer. When none of these applies, the line is dropped.

Only one victim is handled at a time. The block accepts an eviction only while it is idle. It issues one single-cycle query and waits for the response strobe, which arrives a fixed, parameterised number of cycles later. It then presents all selected commands in the same cycle, each on its own valid/ready port. Each command port follows the usual back-pressure rule: once valid is raised, valid and the address hold until ready is seen high at a clock edge, and ready may be high before valid. The block returns to idle at the clock edge on which the last outstanding command completes its handshake.

Top module: `llc_victim_handler`

## Requirements
- R1: `evict_ready` is high exactly while `busy` is low. An eviction is taken on a clock edge where `evict_valid` and `evict_ready` are both high, and `busy` is high from the next cycle until the victim is fully handled.
- R2: In the cycle after an eviction is taken, `lkq_valid` is high for exactly one cycle. `lkq_sel` equals the victim source (0 = SRAM-part victim, query the DRAM presence filter; 1 = DRAM-part victim, query the SRAM tags), and `lkq_addr` equals the victim address.
- R3: A `lkr_valid` strobe is taken only while a query is outstanding, and it is expected `RESP_LAT` cycles after the query cycle. A strobe at any other time has no effect, and no command is raised before the response.
- R4: An SRAM-part victim whose lookup misses (`lkr_hit`=0) raises an invalidate command for the private caches.
- R5: An SRAM-part victim whose lookup hits raises no invalidate command. If it is also clean, no command at all is raised.
- R6: A dirty SRAM-part victim goes to the DRAM-part writeback port when the lookup hits, and to the main-memory writeback port when it misses. Only one of these two ports is used.
- R7: A DRAM-part victim whose SRAM lookup misses raises an invalidate command. If it is dirty, it also raises a main-memory writeback.
- R8: A DRAM-part victim whose SRAM lookup hits is removed silently, with no invalidate and no writeback.
- R9: All selected commands go valid in the cycle after the response strobe and carry the victim address. Each one holds valid and its address stable until its own ready is seen high at a clock edge.
- R10: `busy` falls at the clock edge that completes the last outstanding command handshake, or at the response edge when no command is selected. While `busy` is low, no command valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_valid | input | 1 | Eviction offered |
| evict_ready | output | 1 | Block can take an eviction |
| evict_src | input | 1 | Victim source: 0 SRAM part, 1 DRAM part |
| evict_addr | input | ADDR_W | Victim line address |
| evict_dirty | input | 1 | Victim is modified |
| busy | output | 1 | A victim is being handled |
| lkq_valid | output | 1 | One-cycle lookup query strobe |
| lkq_sel | output | 1 | Lookup target: 0 DRAM presence filter, 1 SRAM tags |
| lkq_addr | output | ADDR_W | Lookup address |
| lkr_valid | input | 1 | Lookup response strobe |
| lkr_hit | input | 1 | Line present in the queried half |
| inv_valid | output | 1 | Back-invalidate private caches |
| inv_ready | input | 1 | Invalidate accepted |
| inv_addr | output | ADDR_W | Address to invalidate |
| dwb_valid | output | 1 | Write victim into the DRAM part |
| dwb_ready | input | 1 | DRAM-part write accepted |
| dwb_addr | output | ADDR_W | DRAM-part write address |
| mwb_valid | output | 1 | Write victim to main memory via writeback buffer |
| mwb_ready | input | 1 | Memory writeback accepted |
| mwb_addr | output | ADDR_W | Memory writeback address |

## Verification
The bench sweeps every combination of source, dirty bit and lookup answer twice: once with all readies already high, and once with readies held low and then released one port at a time. Mixing up the two sources would send a DRAM-part victim to the DRAM writeback port, or leave a DRAM victim that hits in SRAM making noise. Dropping the hold rule would let a command vanish before its handshake. Releasing `busy` one edge late or early would show up in the staggered-release checks. A stray response strobe sent while idle must leave the block idle and quiet, which catches a design that does not gate response capture on an outstanding query.

// File: rtl/vh_pkg.sv
package vh_pkg;

  localparam logic SRC_SRAM = 1'b0;
  localparam logic SRC_DRAM = 1'b1;

  localparam int unsigned CMD_INV = 0;
  localparam int unsigned CMD_DWB = 1;
  localparam int unsigned CMD_MWB = 2;
  localparam int unsigned NUM_CMD = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_ISSUE = 2'd2
  } vh_state_e;

  // Command set for a victim, given its source, dirty bit and the answer
  // from the other half of the cache.
  function automatic logic [NUM_CMD-1:0] vh_plan(input logic src,
                                                 input logic dirty,
                                                 input logic other_hit);
    logic [NUM_CMD-1:0] m;
    m = '0;
    m[CMD_INV] = !other_hit;
    if (dirty) begin
      if (other_hit) m[CMD_DWB] = (src == SRC_SRAM);
      else           m[CMD_MWB] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/vh_intake.sv
module vh_intake #(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_src,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_dirty,
  output logic              v_src,
  output logic [ADDR_W-1:0] v_addr,
  output logic              v_dirty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_src   <= 1'b0;
      v_addr  <= '0;
      v_dirty <= 1'b0;
    end else if (take) begin
      v_src   <= in_src;
      v_addr  <= in_addr;
      v_dirty <= in_dirty;
    end
  end

endmodule

// File: rtl/vh_lookup.sv
module vh_lookup #(
  parameter int unsigned RESP_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rsp_valid,
  output logic q_valid,
  output logic waiting,
  output logic rsp_take
);

  localparam int unsigned CNT_W   = $clog2(RESP_LAT + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAT_V   = CNT_W'(RESP_LAT);

  logic [CNT_W-1:0] wait_cnt;

  assign rsp_take = waiting && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      waiting  <= 1'b0;
      wait_cnt <= '0;
    end else begin
      q_valid <= start;
      if (q_valid) begin
        waiting  <= 1'b1;
        wait_cnt <= CNT_W'(1);
      end else if (rsp_take) begin
        waiting  <= 1'b0;
        wait_cnt <= '0;
      end else if (waiting && wait_cnt != CNT_MAX) begin
        wait_cnt <= wait_cnt + CNT_W'(1);
      end
    end
  end

  AST_QUERY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> !q_valid); // R2

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && rsp_valid) |-> (wait_cnt == LAT_V)); // R3

endmodule

// File: rtl/vh_cmd_port.sv
module vh_cmd_port #(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic              settled
);

  assign settled = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= load_addr;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(addr))); // R9

endmodule

// File: rtl/llc_victim_handler.sv
module llc_victim_handler #(
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned RESP_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  output logic              evict_ready,
  input  logic              evict_src,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              evict_dirty,
  output logic              busy,
  output logic              lkq_valid,
  output logic              lkq_sel,
  output logic [ADDR_W-1:0] lkq_addr,
  input  logic              lkr_valid,
  input  logic              lkr_hit,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [ADDR_W-1:0] inv_addr,
  output logic              dwb_valid,
  input  logic              dwb_ready,
  output logic [ADDR_W-1:0] dwb_addr,
  output logic              mwb_valid,
  input  logic              mwb_ready,
  output logic [ADDR_W-1:0] mwb_addr
);
  import vh_pkg::*;

  vh_state_e state, state_nxt;

  logic              accept;
  logic              v_src, v_dirty;
  logic [ADDR_W-1:0] v_addr;
  logic              q_waiting, rsp_take;
  logic [NUM_CMD-1:0] plan;
  logic [NUM_CMD-1:0] cmd_ready, cmd_valid, cmd_settled;
  logic [ADDR_W-1:0]  cmd_addr [NUM_CMD];

  assign busy        = (state != ST_IDLE);
  assign evict_ready = (state == ST_IDLE);
  assign accept      = evict_valid && evict_ready;

  vh_intake #(.ADDR_W(ADDR_W)) u_intake (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .in_src   (evict_src),
    .in_addr  (evict_addr),
    .in_dirty (evict_dirty),
    .v_src    (v_src),
    .v_addr   (v_addr),
    .v_dirty  (v_dirty)
  );

  vh_lookup #(.RESP_LAT(RESP_LAT)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .rsp_valid (lkr_valid),
    .q_valid   (lkq_valid),
    .waiting   (q_waiting),
    .rsp_take  (rsp_take)
  );

  assign lkq_sel  = v_src;
  assign lkq_addr = v_addr;

  assign plan = vh_plan(v_src, v_dirty, lkr_hit);

  assign cmd_ready[CMD_INV] = inv_ready;
  assign cmd_ready[CMD_DWB] = dwb_ready;
  assign cmd_ready[CMD_MWB] = mwb_ready;

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    vh_cmd_port #(.ADDR_W(ADDR_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rsp_take && plan[g]),
      .load_addr (v_addr),
      .ready     (cmd_ready[g]),
      .valid     (cmd_valid[g]),
      .addr      (cmd_addr[g]),
      .settled   (cmd_settled[g])
    );
  end

  assign inv_valid = cmd_valid[CMD_INV];
  assign inv_addr  = cmd_addr[CMD_INV];
  assign dwb_valid = cmd_valid[CMD_DWB];
  assign dwb_addr  = cmd_addr[CMD_DWB];
  assign mwb_valid = cmd_valid[CMD_MWB];
  assign mwb_addr  = cmd_addr[CMD_MWB];

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (accept) state_nxt = ST_LOOK;
      ST_LOOK:  if (rsp_take) state_nxt = (plan == '0) ? ST_IDLE : ST_ISSUE;
      ST_ISSUE: if (&cmd_settled) state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !evict_ready); // R1

  AST_QUERY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> lkq_valid); // R2

  AST_SRAM_MISS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && v_src == SRC_SRAM && !lkr_hit) |=> inv_valid); // R4

  AST_CLEAN_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !v_dirty && lkr_hit) |=> !(inv_valid || dwb_valid || mwb_valid)); // R5

  AST_DWB_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dwb_valid |-> (v_src == SRC_SRAM && v_dirty && !mwb_valid)); // R6

  AST_DRAM_MISS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && v_src == SRC_DRAM && !lkr_hit) |=> inv_valid); // R7

  AST_DRAM_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && v_src == SRC_DRAM && lkr_hit) |=> (!busy && !inv_valid && !mwb_valid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(inv_valid || dwb_valid || mwb_valid)); // R10

  AST_WAIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    q_waiting |-> (state == ST_LOOK)); // R3

endmodule

// File: tb/tb_llc_victim_handler.sv
module tb_llc_victim_handler;
  localparam int AW  = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic evict_valid, evict_src, evict_dirty;
  logic [AW-1:0] evict_addr;
  logic evict_ready, busy, lkq_valid, lkq_sel;
  logic [AW-1:0] lkq_addr;
  logic lkr_valid, lkr_hit;
  logic [2:0] rdy;
  logic inv_valid, dwb_valid, mwb_valid;
  logic [AW-1:0] inv_addr, dwb_addr, mwb_addr;

  llc_victim_handler #(.ADDR_W(AW), .RESP_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_src(evict_src), .evict_addr(evict_addr), .evict_dirty(evict_dirty),
    .busy(busy),
    .lkq_valid(lkq_valid), .lkq_sel(lkq_sel), .lkq_addr(lkq_addr),
    .lkr_valid(lkr_valid), .lkr_hit(lkr_hit),
    .inv_valid(inv_valid), .inv_ready(rdy[0]), .inv_addr(inv_addr),
    .dwb_valid(dwb_valid), .dwb_ready(rdy[1]), .dwb_addr(dwb_addr),
    .mwb_valid(mwb_valid), .mwb_ready(rdy[2]), .mwb_addr(mwb_addr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] valids();
    return {mwb_valid, dwb_valid, inv_valid};
  endfunction

  function automatic logic [AW-1:0] port_addr(input int k);
    if (k == 0) return inv_addr;
    if (k == 1) return dwb_addr;
    return mwb_addr;
  endfunction

  task automatic run_case(input logic src, input logic dirty, input logic hit,
                          input logic [AW-1:0] a, input bit eager);
    logic [2:0] exp;
    logic [2:0] left;
    exp[0] = !hit;
    exp[1] = (src == 1'b0) && dirty && hit;
    exp[2] = dirty && !hit;
    rdy = eager ? 3'b111 : 3'b000;
    @(negedge clk);
    chk("R1 ready while idle", evict_ready, 1);
    evict_valid = 1'b1; evict_src = src; evict_addr = a; evict_dirty = dirty;
    @(negedge clk);
    evict_valid = 1'b0;
    chk("R1 ready low after accept", evict_ready, 0);
    chk("R1 busy after accept", busy, 1);
    chk("R2 query strobe", lkq_valid, 1);
    chk("R2 query target", lkq_sel, src);
    chk("R2 query address", lkq_addr, a);
    @(negedge clk);
    chk("R2 query single cycle", lkq_valid, 0);
    repeat (LAT - 1) @(negedge clk);
    chk("R3 no command before response", valids(), 0);
    lkr_valid = 1'b1; lkr_hit = hit;
    @(negedge clk);
    lkr_valid = 1'b0; lkr_hit = 1'b0;
    chk(src ? "R7 invalidate on DRAM victim" : "R4 invalidate on SRAM victim", inv_valid, exp[0]);
    chk("R6 DRAM-part writeback", dwb_valid, exp[1]);
    chk(src ? "R7 memory writeback" : "R6 memory writeback", mwb_valid, exp[2]);
    for (int k = 0; k < 3; k++)
      if (exp[k]) chk("R9 command address", port_addr(k), a);
    if (exp == 3'b000) begin
      chk(src ? "R8 silent drop busy" : "R5 clean drop busy", busy, 0);
      chk("R10 ready after drop", evict_ready, 1);
    end else if (eager) begin
      @(negedge clk);
      rdy = 3'b000;
      chk("R9 handshake with early ready", valids(), 0);
      chk("R10 busy after final handshake", busy, 0);
    end else begin
      repeat (2) @(negedge clk);
      chk("R9 valid held without ready", valids(), exp);
      for (int k = 0; k < 3; k++)
        if (exp[k]) chk("R9 address stable", port_addr(k), a);
      left = exp;
      for (int k = 0; k < 3; k++) begin
        if (exp[k]) begin
          rdy[k] = 1'b1;
          @(negedge clk);
          rdy[k] = 1'b0;
          left[k] = 1'b0;
          chk("R9 valid drops after handshake", valids(), left);
          chk("R10 busy tracks pending commands", busy, (left != 3'b000));
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    evict_valid = 1'b0; evict_src = 1'b0; evict_addr = '0; evict_dirty = 1'b0;
    lkr_valid = 1'b0; lkr_hit = 1'b0; rdy = 3'b000;
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R1 reset ready", evict_ready, 1);
    chk("R10 reset commands", valids(), 0);
    chk("R2 reset query", lkq_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    lkr_valid = 1'b1; lkr_hit = 1'b1;
    @(negedge clk);
    lkr_valid = 1'b0; lkr_hit = 1'b0;
    chk("R3 stray strobe busy", busy, 0);
    chk("R3 stray strobe commands", valids(), 0);
    @(negedge clk);
    chk("R3 stray strobe later", valids(), 0);
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
          for (int h = 0; h < 2; h++)
            run_case(s[0], d[0], h[0],
                     AW'(16'h1357 ^ (s * 16'h0400) ^ (d * 16'h0030) ^ (h * 16'h0005) ^ (e * 16'hA000)),
                     e[0]);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule